// File: doc/BRIEF.md
# I2C Forward-Channel Address Router

This block sits beside an I2C bit engine on one end of a bidirectional control link. Each time the engine decodes an address byte, the block decides how the transaction is handled. A local-side access may be serviced by this device's own registers, sent across the link to the far end, or ignored. A far-side access arriving over the link may reach the local registers, be refused, or be passed on to a target on the local bus. The decision and the target address for a forwarded access are registered. They stay on the outputs until the engine reports a stop or a repeated start.

Forwarding has two modes. In selective mode, only addresses that equal the programmed serializer ID, or that hit a valid entry of an eight-entry remote target table, are forwarded, and they keep their own address. In pass-all mode, every address other than the local ID is forwarded, and its address is replaced by the serializer ID. A separate lock refuses far-side writes to the local registers. It does not affect far-side traffic to other local-bus targets. The block also keeps a sticky flag for errors in the forward channel sequence, and that flag is cleared by a request pulse.

Top module: `i2c_fwd_router`

## Requirements
- R1: After reset, `fwd`, `local_acc`, `dn_pass`, `reject` and `seq_err` are 0, and `route_addr` is 0.
- R2: A local-side access (`from_remote`=0) whose address equals `local_id` asserts only `local_acc`, whatever the value of `pass_all`.
- R3: With `pass_all`=1, a local-side access whose address differs from `local_id` asserts `fwd`, and `route_addr` equals `ser_id`.
- R4: With `pass_all`=0, a local-side access is forwarded with `route_addr` equal to its own address when that address equals `ser_id` or equals entry i of `tgt_ids` (bits i*7+6..i*7) while `tgt_valid[i]`=1. This holds for every index, including 0 and 7.
- R5: With `pass_all`=0, a local-side address that equals neither `local_id`, nor `ser_id`, nor any valid table entry asserts no decision output. An entry whose valid bit is 0 never matches.
- R6: A far-side access (`from_remote`=1) to `local_id` asserts `local_acc`. The exception is a write (`rw`=0) while `local_wr_dis`=1: that access asserts only `reject`.
- R7: A far-side access to any address other than `local_id` asserts `dn_pass`, with `route_addr` equal to that address, whether `local_wr_dis` is 0 or 1.
- R8: The decision is taken from the inputs in the cycle where `addr_valid`=1 and appears on the outputs one cycle later. It then holds until `txn_end`, and changes to the address, mode or lock inputs in the meantime have no effect on it.
- R9: `txn_end`=1 without `addr_valid` clears all decision outputs and `route_addr` on the next cycle.
- R10: `seq_err` goes to 1 the cycle after `seq_err_evt`=1 and stays set until `seq_err_clr`=1. If both arrive in the same cycle, the set wins.
- R11: At most one of `fwd`, `local_acc`, `dn_pass` and `reject` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_valid | input | 1 | Address byte decoded this cycle |
| addr | input | 7 | Decoded target address |
| rw | input | 1 | 1 = read, 0 = write |
| from_remote | input | 1 | 1 = access arrived over the control link |
| txn_end | input | 1 | Stop or repeated start seen |
| local_id | input | 7 | This device's own I2C address |
| ser_id | input | 7 | Far-end serializer address |
| tgt_ids | input | 56 | Remote target table, 8 entries of 7 bits |
| tgt_valid | input | 8 | Valid bit per table entry |
| pass_all | input | 1 | Forward all non-local addresses, remapped to `ser_id` |
| local_wr_dis | input | 1 | Refuse far-side writes to local registers |
| seq_err_evt | input | 1 | Forward-channel sequence error detected |
| seq_err_clr | input | 1 | Clear request for the sequence-error flag |
| fwd | output | 1 | Forward across the control link |
| local_acc | output | 1 | Service with local registers |
| dn_pass | output | 1 | Pass a far-side access onto the local bus |
| reject | output | 1 | Far-side write to local registers refused |
| route_addr | output | 7 | Address used for a forwarded or passed access |
| seq_err | output | 1 | Sticky sequence-error flag |

## Verification
The bound checker watches several behaviours on every cycle: the exclusivity of the four decision outputs, holding between address and end of transaction, clearing on end of transaction, the sticky set/clear of the error flag with set priority, and the single-cycle outcomes of pass-all remapping, the write lock and far-side downstream passing. The bench scenarios are needed for the selective forwarding table. Only concrete patterns can show that boundary indices hit, that invalid entries miss, and that unmatched addresses are ignored. The scenarios also show that a read slips past the lock and that mid-transaction input changes leave a held decision untouched.

// File: rtl/i2c_fwd_router.sv
module i2c_fwd_router #(
  parameter int AW = 7,
  parameter int NT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_valid,
  input  logic [AW-1:0]    addr,
  input  logic             rw,
  input  logic             from_remote,
  input  logic             txn_end,
  input  logic [AW-1:0]    local_id,
  input  logic [AW-1:0]    ser_id,
  input  logic [NT*AW-1:0] tgt_ids,
  input  logic [NT-1:0]    tgt_valid,
  input  logic             pass_all,
  input  logic             local_wr_dis,
  input  logic             seq_err_evt,
  input  logic             seq_err_clr,
  output logic             fwd,
  output logic             local_acc,
  output logic             dn_pass,
  output logic             reject,
  output logic [AW-1:0]    route_addr,
  output logic             seq_err
);

  logic [NT-1:0] hit;
  for (genvar i = 0; i < NT; i++) begin : g_tgt
    assign hit[i] = tgt_valid[i] && (tgt_ids[i*AW +: AW] == addr);
  end

  wire is_local  = (addr == local_id);
  wire far_known = (addr == ser_id) || (|hit);

  logic          n_fwd, n_loc, n_dn, n_rej;
  logic [AW-1:0] n_addr;

  always_comb begin
    n_fwd  = 1'b0;
    n_loc  = 1'b0;
    n_dn   = 1'b0;
    n_rej  = 1'b0;
    n_addr = '0;
    if (from_remote) begin
      if (is_local) begin
        if (!rw && local_wr_dis) n_rej = 1'b1;
        else                     n_loc = 1'b1;
      end else begin
        n_dn   = 1'b1;
        n_addr = addr;
      end
    end else if (is_local) begin
      n_loc = 1'b1;
    end else if (pass_all) begin
      n_fwd  = 1'b1;
      n_addr = ser_id;
    end else if (far_known) begin
      n_fwd  = 1'b1;
      n_addr = addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {fwd, local_acc, dn_pass, reject} <= '0;
      route_addr <= '0;
    end else if (addr_valid) begin
      {fwd, local_acc, dn_pass, reject} <= {n_fwd, n_loc, n_dn, n_rej};
      route_addr <= n_addr;
    end else if (txn_end) begin
      {fwd, local_acc, dn_pass, reject} <= '0;
      route_addr <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seq_err <= 1'b0;
    else        seq_err <= seq_err_evt | (seq_err & ~seq_err_clr);
  end

endmodule

// File: rtl/i2c_fwd_router_chk.sv
module i2c_fwd_router_chk #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr_valid,
  input logic [AW-1:0] addr,
  input logic          rw,
  input logic          from_remote,
  input logic          txn_end,
  input logic [AW-1:0] local_id,
  input logic [AW-1:0] ser_id,
  input logic          pass_all,
  input logic          local_wr_dis,
  input logic          seq_err_evt,
  input logic          seq_err_clr,
  input logic          fwd,
  input logic          local_acc,
  input logic          dn_pass,
  input logic          reject,
  input logic [AW-1:0] route_addr,
  input logic          seq_err
);

  assert_one_decision_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fwd, local_acc, dn_pass, reject}));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_valid && !txn_end) |=> $stable({fwd, local_acc, dn_pass, reject, route_addr}));

  assert_end_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_end && !addr_valid) |=> !(fwd || local_acc || dn_pass || reject) && route_addr == '0);

  assert_remap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !from_remote && pass_all && addr != local_id)
      |=> fwd && route_addr == $past(ser_id));

  assert_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && from_remote && !rw && local_wr_dis && addr == local_id)
      |=> reject && !local_acc);

  assert_downstream_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && from_remote && addr != local_id)
      |=> dn_pass && route_addr == $past(addr));

  assert_err_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err_evt |=> seq_err);

  assert_err_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_err_clr && !seq_err_evt) |=> !seq_err);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_err_clr && !seq_err_evt) |=> $stable(seq_err));

endmodule

bind i2c_fwd_router i2c_fwd_router_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr(addr), .rw(rw),
  .from_remote(from_remote), .txn_end(txn_end), .local_id(local_id),
  .ser_id(ser_id), .pass_all(pass_all), .local_wr_dis(local_wr_dis),
  .seq_err_evt(seq_err_evt), .seq_err_clr(seq_err_clr), .fwd(fwd),
  .local_acc(local_acc), .dn_pass(dn_pass), .reject(reject),
  .route_addr(route_addr), .seq_err(seq_err)
);

// File: tb/i2c_fwd_router_tb.sv
module i2c_fwd_router_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_valid = 0, rw = 0, from_remote = 0, txn_end = 0;
  logic [6:0] addr = '0;
  logic [6:0] local_id = 7'h60, ser_id = 7'h58;
  logic [55:0] tgt_ids = '0;
  logic [7:0] tgt_valid = '0;
  logic pass_all = 0, local_wr_dis = 0, seq_err_evt = 0, seq_err_clr = 0;
  logic fwd, local_acc, dn_pass, reject, seq_err;
  logic [6:0] route_addr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  i2c_fwd_router u_dut (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr(addr), .rw(rw),
    .from_remote(from_remote), .txn_end(txn_end), .local_id(local_id),
    .ser_id(ser_id), .tgt_ids(tgt_ids), .tgt_valid(tgt_valid),
    .pass_all(pass_all), .local_wr_dis(local_wr_dis),
    .seq_err_evt(seq_err_evt), .seq_err_clr(seq_err_clr), .fwd(fwd),
    .local_acc(local_acc), .dn_pass(dn_pass), .reject(reject),
    .route_addr(route_addr), .seq_err(seq_err)
  );

  localparam logic [3:0] D_NONE = 4'b0000, D_FWD = 4'b1000, D_LOC = 4'b0100,
                         D_DN = 4'b0010, D_REJ = 4'b0001;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_dec(string req, logic [3:0] exp_d, logic [6:0] exp_a);
    chk(req, {28'd0, fwd, local_acc, dn_pass, reject}, {28'd0, exp_d});
    chk(req, {25'd0, route_addr}, {25'd0, exp_a});
  endtask

  task automatic issue(logic [6:0] a, logic r, logic rem);
    @(negedge clk);
    addr = a; rw = r; from_remote = rem; addr_valid = 1;
    @(negedge clk);
    addr_valid = 0;
  endtask

  task automatic end_txn();
    @(negedge clk);
    txn_end = 1;
    @(negedge clk);
    txn_end = 0;
  endtask

  task automatic t_reset();
    chk_dec("R1", D_NONE, 7'h00);
    chk("R1", {31'd0, seq_err}, 32'd0);
  endtask

  task automatic t_local();
    pass_all = 0; issue(7'h60, 1, 0); chk_dec("R2", D_LOC, 7'h00); end_txn();
    pass_all = 1; issue(7'h60, 0, 0); chk_dec("R2 R11", D_LOC, 7'h00); end_txn();
    pass_all = 0;
  endtask

  task automatic t_pass_all();
    pass_all = 1;
    issue(7'h12, 0, 0); chk_dec("R3", D_FWD, 7'h58); end_txn();
    issue(7'h50, 1, 0); chk_dec("R3", D_FWD, 7'h58); end_txn();
    pass_all = 0;
  endtask

  task automatic t_selective();
    issue(7'h58, 0, 0); chk_dec("R4 ser", D_FWD, 7'h58); end_txn();
    issue(7'h50, 1, 0); chk_dec("R4 idx0", D_FWD, 7'h50); end_txn();
    issue(7'h21, 0, 0); chk_dec("R4 idx3", D_FWD, 7'h21); end_txn();
    issue(7'h7F, 0, 0); chk_dec("R4 idx7", D_FWD, 7'h7F); end_txn();
    issue(7'h33, 0, 0); chk_dec("R5 invalid", D_NONE, 7'h00); end_txn();
    issue(7'h12, 0, 0); chk_dec("R5 miss", D_NONE, 7'h00); end_txn();
  endtask

  task automatic t_lock();
    local_wr_dis = 1;
    issue(7'h60, 0, 1); chk_dec("R6 wr locked", D_REJ, 7'h00); end_txn();
    issue(7'h60, 1, 1); chk_dec("R6 rd locked", D_LOC, 7'h00); end_txn();
    local_wr_dis = 0;
    issue(7'h60, 0, 1); chk_dec("R6 wr open", D_LOC, 7'h00); end_txn();
  endtask

  task automatic t_downstream();
    local_wr_dis = 1;
    issue(7'h12, 0, 1); chk_dec("R7 locked", D_DN, 7'h12); end_txn();
    local_wr_dis = 0;
    issue(7'h58, 0, 1); chk_dec("R7 open", D_DN, 7'h58); end_txn();
  endtask

  task automatic t_hold();
    issue(7'h21, 0, 0);
    addr = 7'h60; pass_all = 1; local_wr_dis = 1; from_remote = 1;
    repeat (3) @(negedge clk);
    chk_dec("R8", D_FWD, 7'h21);
    pass_all = 0; local_wr_dis = 0; from_remote = 0;
    end_txn();
    chk_dec("R9", D_NONE, 7'h00);
  endtask

  task automatic t_seq_err();
    @(negedge clk); seq_err_evt = 1;
    @(negedge clk); seq_err_evt = 0;
    chk("R10 set", {31'd0, seq_err}, 32'd1);
    repeat (3) @(negedge clk);
    chk("R10 sticky", {31'd0, seq_err}, 32'd1);
    seq_err_clr = 1;
    @(negedge clk); seq_err_clr = 0;
    chk("R10 clear", {31'd0, seq_err}, 32'd0);
    seq_err_evt = 1; seq_err_clr = 1;
    @(negedge clk); seq_err_evt = 0; seq_err_clr = 0;
    chk("R10 set wins", {31'd0, seq_err}, 32'd1);
    seq_err_clr = 1;
    @(negedge clk); seq_err_clr = 0;
    chk("R10 clear again", {31'd0, seq_err}, 32'd0);
  endtask

  initial begin
    tgt_ids[0*7 +: 7] = 7'h50; tgt_valid[0] = 1;
    tgt_ids[3*7 +: 7] = 7'h21; tgt_valid[3] = 1;
    tgt_ids[5*7 +: 7] = 7'h33; tgt_valid[5] = 0;
    tgt_ids[7*7 +: 7] = 7'h7F; tgt_valid[7] = 1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_local();
    t_pass_all();
    t_selective();
    t_lock();
    t_downstream();
    t_hold();
    t_seq_err();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule